// File: doc/BRIEF.md
# Address Table Search Engine

This block walks an address table held in an external single-port RAM and reports the lowest entry index that satisfies a search. A search is launched by a one-cycle `start_i` pulse carrying a mode and, where the mode needs them, a 48-bit MAC key and a 12-bit VLAN key. The engine asks for one table word per cycle and receives it one cycle later. It returns a done pulse with a found flag and an index. Four searches are offered: an exact MAC+VLAN match, a VLAN-entry match, the first unused slot, and the first entry that may be displaced by ageing.

Each 64-bit table word is decoded in place. Bits 63:62 hold the unicast class (0 pinned, 1 fresh, 2 vendor-prefix, 3 used). Bits 61:60 hold the entry kind (0 empty, 1 MAC, 2 VLAN, 3 MAC with VLAN). Bits 59:48 hold the VLAN ID and bits 47:0 hold the MAC address, with its first byte in 47:40. Bit 40, the lowest bit of that first byte, is the group (multicast) flag.

The sequencer has four states. IDLE waits for a start. PRIME issues the read of index 0. SCAN judges the word that has just arrived while it fetches the next one. DONE pulses done. The transitions are: IDLE→PRIME on start; PRIME→SCAN always; SCAN→DONE on a hit or when the last index has been judged, otherwise SCAN→SCAN; DONE→IDLE always.

Top module: `addr_table_scanner`

## Requirements
- R1: With mode 0, an entry qualifies only if its kind (bits 61:60) is 1 or 3, its VLAN ID (bits 59:48) equals `vid_i` and its bits 47:0 equal `mac_i`. Entries of kind 0 or 2 never qualify, even when their fields are equal.
- R2: With mode 1, an entry qualifies only if its kind is 2 and its VLAN ID equals `vid_i`. The MAC key is ignored.
- R3: With mode 2, an entry qualifies if its kind is 0.
- R4: With mode 3, an entry qualifies if its kind is 1 or 3, bit 40 is 0 and its unicast class (bits 63:62) is 1 or 3. Multicast entries and entries of class 0 or 2 are skipped.
- R5: When several entries qualify, the lowest index is returned.
- R6: When no entry qualifies, `found_o` is 0 and `index_o` is 0. Done then arrives DEPTH+1 cycles after the start edge.
- R7: A hit at index k raises `done_o` exactly k+2 clock edges after the edge that samples `start_i`. `done_o` is high for one cycle only.
- R8: A `start_i` seen while `busy_o` is high is ignored. The running search keeps its original mode and keys, and no new search follows it.
- R9: Reads are issued only while busy. The addresses run 0,1,2,… in order. A search issues min(k+2, DEPTH) reads, or DEPTH when nothing qualifies.
- R10: After reset, `busy_o`, `done_o`, `found_o`, `index_o` and `ram_rd_o` are all 0.
- R11: `found_o` and `index_o` hold their last result while idle, until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a search (sampled in IDLE only) |
| mode_i | input | 2 | 0 MAC match, 1 VLAN match, 2 empty slot, 3 ageable |
| mac_i | input | 48 | MAC key |
| vid_i | input | 12 | VLAN key |
| busy_o | output | 1 | Search in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Result valid flag |
| index_o | output | IDX_W | Lowest qualifying index |
| ram_rd_o | output | 1 | Table read request |
| ram_addr_o | output | IDX_W | Table read address |
| ram_data_i | input | 64 | Table word, valid one cycle after the request |

## Verification
The bench builds the engine with DEPTH=16. This makes a full scan to the end short, so both the not-found latency of DEPTH+1 and a hit on the very last index can be checked directly. The table holds decoy entries: an empty slot whose fields equal a MAC key, a VLAN entry and a MAC+VLAN entry sharing a VLAN ID, a multicast entry of the fresh class, and pinned and vendor-prefix entries. Every skip rule therefore has an entry placed ahead of the one that should win. A late start pulse aimed at a different mode shows that an in-flight search cannot be redirected.

// File: rtl/ats_pkg.sv
package ats_pkg;
    localparam int ENTRY_W = 64;

    typedef enum logic [1:0] {
        MODE_ADDR = 2'd0,
        MODE_VLAN = 2'd1,
        MODE_FREE = 2'd2,
        MODE_AGE  = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        KIND_EMPTY = 2'd0,
        KIND_MAC   = 2'd1,
        KIND_VLAN  = 2'd2,
        KIND_VMAC  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        UC_PINNED = 2'd0,
        UC_FRESH  = 2'd1,
        UC_VENDOR = 2'd2,
        UC_USED   = 2'd3
    } uclass_e;

    // Packed view of one table word, most significant field first.
    typedef struct packed {
        uclass_e     ucls;
        kind_e       kind;
        logic [11:0] vid;
        logic [47:0] mac;
    } entry_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRIME,
        S_SCAN,
        S_DONE
    } state_e;
endpackage

// File: rtl/ats_qualify.sv
module ats_qualify
    import ats_pkg::*;
(
    input  scan_mode_e           mode_i,
    input  logic [47:0]          mac_i,
    input  logic [11:0]          vid_i,
    input  logic [ENTRY_W-1:0]   entry_i,
    output logic                 hit_o
);
    entry_t e;
    logic   is_addr;
    logic   vid_eq;
    logic   mac_eq;
    logic   evictable;

    assign e         = entry_t'(entry_i);
    assign is_addr   = (e.kind == KIND_MAC) || (e.kind == KIND_VMAC);
    assign vid_eq    = (e.vid == vid_i);
    assign mac_eq    = (e.mac == mac_i);
    // bit 40 of the word is the group flag of the first address byte
    assign evictable = !e.mac[40] && ((e.ucls == UC_FRESH) || (e.ucls == UC_USED));

    always_comb begin
        unique case (mode_i)
            MODE_ADDR: hit_o = is_addr && vid_eq && mac_eq;
            MODE_VLAN: hit_o = (e.kind == KIND_VLAN) && vid_eq;
            MODE_FREE: hit_o = (e.kind == KIND_EMPTY);
            MODE_AGE:  hit_o = is_addr && evictable;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ats_sequencer.sv
module ats_sequencer
    import ats_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [47:0]      mac_i,
    input  logic [11:0]      vid_i,
    input  logic             hit_i,
    output scan_mode_e       key_mode_o,
    output logic [47:0]      key_mac_o,
    output logic [11:0]      key_vid_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             found_o,
    output logic [IDX_W-1:0] index_o,
    output logic             ram_rd_o,
    output logic [IDX_W-1:0] ram_addr_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic             at_end;

    assign at_end = (ptr_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_PRIME;
            S_PRIME: state_d = S_SCAN;
            S_SCAN:  if (hit_i || at_end) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register together with the scan pointer, key and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ptr_q      <= '0;
            key_mode_o <= MODE_ADDR;
            key_mac_o  <= '0;
            key_vid_o  <= '0;
            found_o    <= 1'b0;
            index_o    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                ptr_q      <= '0;
                key_mode_o <= scan_mode_e'(mode_i);
                key_mac_o  <= mac_i;
                key_vid_o  <= vid_i;
            end else if (state_q == S_SCAN) begin
                if (hit_i || at_end) begin
                    found_o <= hit_i;
                    index_o <= hit_i ? ptr_q : '0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy_o     = (state_q != S_IDLE);
        done_o     = (state_q == S_DONE);
        ram_rd_o   = (state_q == S_PRIME) || (state_q == S_SCAN && !at_end);
        ram_addr_o = (state_q == S_SCAN && !at_end) ? ptr_q + 1'b1 : '0;
    end
endmodule

// File: rtl/addr_table_scanner.sv
module addr_table_scanner
    import ats_pkg::*;
#(
    parameter int  DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [47:0]        mac_i,
    input  logic [11:0]        vid_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               found_o,
    output logic [IDX_W-1:0]   index_o,
    output logic               ram_rd_o,
    output logic [IDX_W-1:0]   ram_addr_o,
    input  logic [ENTRY_W-1:0] ram_data_i
);
    scan_mode_e  key_mode;
    logic [47:0] key_mac;
    logic [11:0] key_vid;
    logic        hit;

    ats_qualify u_qual (
        .mode_i  (key_mode),
        .mac_i   (key_mac),
        .vid_i   (key_vid),
        .entry_i (ram_data_i),
        .hit_o   (hit)
    );

    ats_sequencer #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .mac_i      (mac_i),
        .vid_i      (vid_i),
        .hit_i      (hit),
        .key_mode_o (key_mode),
        .key_mac_o  (key_mac),
        .key_vid_o  (key_vid),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .found_o    (found_o),
        .index_o    (index_o),
        .ram_rd_o   (ram_rd_o),
        .ram_addr_o (ram_addr_o)
    );
endmodule

// File: rtl/ats_checker.sv
module ats_checker #(
    parameter int DEPTH = 2,
    parameter int IDX_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             found_o,
    input logic [IDX_W-1:0] index_o,
    input logic             ram_rd_o,
    input logic [IDX_W-1:0] ram_addr_o
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    a_r8_idle_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && !done_o);

    a_r9_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_o |-> busy_o && !done_o);

    a_r9_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_o |-> int'(ram_addr_o) < DEPTH);

    a_r5_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && found_o |-> int'(index_o) < DEPTH);

    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && $past(!busy_o) |-> $stable(found_o) && $stable(index_o));
endmodule

bind addr_table_scanner ats_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .found_o    (found_o),
    .index_o    (index_o),
    .ram_rd_o   (ram_rd_o),
    .ram_addr_o (ram_addr_o)
);

// File: tb/addr_table_scanner_test.sv
module addr_table_scanner_test;
    localparam int DEPTH = 16;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = '0;
    logic [47:0]   mac = '0;
    logic [11:0]   vid = '0;
    logic          busy, done, found, ram_rd;
    logic [IW-1:0] index, ram_addr;
    logic [63:0]   rdata = '0;
    logic [63:0]   mem [DEPTH];
    int            rd_cnt = 0;
    bit            seq_bad = 0;
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    addr_table_scanner #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .mac_i(mac), .vid_i(vid), .busy_o(busy), .done_o(done),
        .found_o(found), .index_o(index), .ram_rd_o(ram_rd),
        .ram_addr_o(ram_addr), .ram_data_i(rdata)
    );

    // table RAM model: one cycle read latency, tracks read order
    always @(posedge clk) begin
        if (ram_rd) begin
            rdata <= mem[ram_addr];
            if (int'(ram_addr) != rd_cnt) seq_bad <= 1'b1;
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [63:0] mk(logic [1:0] u, logic [1:0] k,
                                       logic [11:0] v, logic [47:0] m);
        return {u, k, v, m};
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic search(input logic [1:0] m, input logic [47:0] a, input logic [11:0] v,
                          output logic f, output int ix, output int lat, output int rds);
        @(negedge clk);
        mode = m; mac = a; vid = v; rd_cnt = 0; seq_bad = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        f = found; ix = int'(index); rds = rd_cnt;
    endtask

    typedef struct packed {
        logic [1:0]  m;
        logic [47:0] a;
        logic [11:0] v;
        logic        f;
        logic [3:0]  ix;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'd0, 48'h0011_2233_4455, 12'd0,     1'b1, 4'd1},
        '{2'd0, 48'h0011_2233_4455, 12'd7,     1'b1, 4'd2},
        '{2'd0, 48'h0011_2233_4455, 12'd3,     1'b0, 4'd0},
        '{2'd0, 48'hDEAD_BEEF_0001, 12'd9,     1'b1, 4'd9},
        '{2'd0, 48'hFFFF_FFFF_FFFF, 12'hABC,   1'b1, 4'd15},
        '{2'd1, 48'h1234_5678_9ABC, 12'd5,     1'b1, 4'd0},
        '{2'd1, 48'h0,              12'd7,     1'b1, 4'd5},
        '{2'd1, 48'h0,              12'd99,    1'b0, 4'd0},
        '{2'd2, 48'h0,              12'd0,     1'b1, 4'd4},
        '{2'd3, 48'h0,              12'd0,     1'b1, 4'd6},
        '{2'd1, 48'h0,              12'd14,    1'b1, 4'd14}
    };

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string tg;
        logic f;
        int ix, lat, rds, elat, erds;

        mem[0]  = mk(2'd0, 2'd2, 12'd5,   48'h0);
        mem[1]  = mk(2'd0, 2'd1, 12'd0,   48'h0011_2233_4455);
        mem[2]  = mk(2'd2, 2'd3, 12'd7,   48'h0011_2233_4455);
        mem[3]  = mk(2'd1, 2'd1, 12'd0,   48'h01AA_BBCC_DDEE);
        mem[4]  = mk(2'd0, 2'd0, 12'd9,   48'hDEAD_BEEF_0001);
        mem[5]  = mk(2'd0, 2'd2, 12'd7,   48'h0);
        mem[6]  = mk(2'd3, 2'd3, 12'd3,   48'h0200_0000_0001);
        mem[7]  = mk(2'd1, 2'd1, 12'd0,   48'h0200_0000_0002);
        mem[8]  = mk(2'd0, 2'd2, 12'd5,   48'h0);
        mem[9]  = mk(2'd0, 2'd1, 12'd9,   48'hDEAD_BEEF_0001);
        mem[10] = mk(2'd0, 2'd0, 12'd0,   48'h0);
        for (int i = 11; i < 15; i++) mem[i] = mk(2'd0, 2'd2, 12'(i), 48'h0);
        mem[15] = mk(2'd0, 2'd1, 12'hABC, 48'hFFFF_FFFF_FFFF);

        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !done && !found && index == 0 && !ram_rd, "R10 reset outputs",
              {busy, done, found, ram_rd}, 0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            search(VECS[i].m, VECS[i].a, VECS[i].v, f, ix, lat, rds);
            case (VECS[i].m)
                2'd0: tg = "R1";
                2'd1: tg = "R2";
                2'd2: tg = "R3";
                default: tg = "R4";
            endcase
            if (!VECS[i].f) tg = {tg, "/R6"};
            elat = VECS[i].f ? int'(VECS[i].ix) + 2 : DEPTH + 1;
            erds = VECS[i].f ? ((int'(VECS[i].ix) + 2 < DEPTH) ? int'(VECS[i].ix) + 2 : DEPTH) : DEPTH;
            check(f == VECS[i].f, {tg, " found"}, f, VECS[i].f);
            check(ix == int'(VECS[i].ix), {tg, " index"}, ix, VECS[i].ix);
            check(lat == elat, "R7 latency", lat, elat);
            check(rds == erds && !seq_bad, "R9 read count/order", rds, erds);
            @(negedge clk);
            check(!done, "R7 done one cycle", done, 0);
        end

        // R5: two VLAN-5 entries and two ageable entries, lowest wins
        search(2'd1, 48'h0, 12'd5, f, ix, lat, rds);
        check(f && ix == 0, "R5 lowest vlan index", ix, 0);
        search(2'd3, 48'h0, 12'd0, f, ix, lat, rds);
        check(f && ix == 6, "R5 lowest ageable index", ix, 6);

        // R6: table full, no empty slot
        mem[4]  = mk(2'd0, 2'd2, 12'd200, 48'h0);
        mem[10] = mk(2'd0, 2'd2, 12'd201, 48'h0);
        search(2'd2, 48'h0, 12'd0, f, ix, lat, rds);
        check(!f && ix == 0, "R6 no free found", f, 0);
        check(lat == DEPTH + 1, "R6 not-found latency", lat, DEPTH + 1);

        // R4: only pinned, vendor-prefix and multicast address entries remain
        mem[6] = mk(2'd0, 2'd3, 12'd3, 48'h0200_0000_0001);
        mem[7] = mk(2'd2, 2'd1, 12'd0, 48'h0200_0000_0002);
        search(2'd3, 48'h0, 12'd0, f, ix, lat, rds);
        check(!f, "R4 skip pinned/vendor/multicast", f, 0);

        // R8: start pulse mid-search with another mode is ignored
        @(negedge clk);
        mode = 2'd0; mac = 48'hFFFF_FFFF_FFFF; vid = 12'hABC; rd_cnt = 0; seq_bad = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        mode = 2'd1; vid = 12'd5; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 1000) begin @(negedge clk); lat++; end
        check(found && index == 15, "R8 in-flight search unchanged", index, 15);
        check(lat == 17, "R8 latency unchanged", lat, 17);
        @(negedge clk);
        check(!busy, "R8 no relaunch", busy, 0);

        // R11: result held while idle, no reads
        rd_cnt = 0;
        repeat (5) @(negedge clk);
        check(found && index == 15, "R11 result held", index, 15);
        check(rd_cnt == 0, "R9 no reads idle", rd_cnt, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule